// File: doc/BRIEF.md
# Loopback Multitexture Pixel Pipe

This block is the texturing sequencer of one pixel pipe. It takes one pixel at a time: a frame buffer address, a base colour and a count of textures to apply. A fixed number of texture lanes, set at elaboration, each sample one texture per clock. The pipe feeds the pixel back through those lanes until every texture of the current pass is applied. Inside a lane chain each texel is folded into the running colour with a per-channel modulate.

A pass may apply only a limited number of textures. A pixel that needs more is split into several passes. The first pass starts from the base colour and writes its result to the frame buffer. Each later pass starts from white and applies its own textures. It then reads the stored value back through a synchronous port with one cycle of latency, modulates the two colours together and writes the product back. A pixel with no textures goes straight to the write. While a pixel is in flight the upstream input is stalled. The final write comes with a one-cycle done strobe.

The controller has five states:

| State | What it does | Transitions |
|---|---|---|
| IDLE | Waits for a pixel. | Goes to TEX on an accepted pixel with textures. Goes to WRITE on a pixel with none. |
| TEX | Runs one loop through the lanes. | Stays in TEX while the pass has textures left. On the last loop it goes to WRITE in the first pass and to FBRD in a later pass. |
| FBRD | Issues the frame buffer read. | Always goes to MERGE. |
| MERGE | Modulates the returned value into the colour. | Always goes to WRITE. |
| WRITE | Stores the colour. | Goes to IDLE when all textures are applied. Otherwise it goes to TEX and the next pass begins. |

Top module: `lbt_pipe`

## Requirements
- R1: While reset is asserted and after it is released with no pixel offered, in_ready is 1 and busy, fb_rd_en, fb_wr_en and done are 0, with pass_idx 0.
- R2: Texture k (global index from 0) of the pixel at address a gives texel byte c (c=0 in bits 7:0, c=1 in bits 15:8, c=2 in bits 23:16) equal to ((a mod 256) + 17*k + 85*c) mod 256, OR 0x80.
- R3: The colour is combined with each texel, in ascending texture index, per channel as (x*y + 255) >> 8. The first pass starts from the base colour.
- R4: A pass applying t textures spends ceil(t/NUM_TU) cycles looping. busy stays high for the loop cycles, plus one write cycle per pass, plus two extra cycles (read, merge) for each pass after the first.
- R5: in_ready is 1 only when idle. A pixel is accepted on a clock edge with in_valid and in_ready both high. Input offered while busy is ignored and leaves the writes and the final colour unchanged.
- R6: A pixel with a texture count of 0 is written unchanged, with done high, in the first cycle after acceptance.
- R7: The textures are split into passes of PASS_MAX textures each, with the remainder in the last pass. Each pass ends with one fb_wr_en cycle at the pixel's address. pass_idx counts passes from 0 and steps by one.
- R8: A later pass starts from 0xFFFFFF. After its loops it asserts fb_rd_en for one cycle. In the next cycle it modulates the returned word with its own colour per channel as in R3. In the cycle after that it writes the product.
- R9: done is high for exactly one cycle, the cycle of the final write, and out_colour then equals the written value. pass_idx shows the current pass in every busy cycle.
- R10: fb_rd_en occurs only in passes after the first, exactly once per such pass, and never in the same cycle as fb_wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel is offered |
| in_ready | output | 1 | The pipe is idle and takes the pixel |
| in_addr | input | ADDR_W | Frame buffer address of the pixel |
| in_base | input | 24 | Base colour of the pixel |
| in_tex_cnt | input | CNT_W | Number of textures to apply |
| busy | output | 1 | A pixel is in flight; upstream stalled |
| fb_rd_en | output | 1 | Frame buffer read request |
| fb_wr_en | output | 1 | Frame buffer write strobe |
| fb_addr | output | ADDR_W | Frame buffer address for read and write |
| fb_wr_data | output | 24 | Colour written to the frame buffer |
| fb_rd_data | input | 24 | Read data, valid one cycle after fb_rd_en |
| done | output | 1 | The final colour of the pixel is ready |
| out_colour | output | 24 | Final colour, valid with done |
| pass_idx | output | CNT_W | Index of the current pass |

## Verification
Pixels with 0, 1, 2 and 3 textures separate the straight-through path from full and partly filled lane loops. A count of exactly PASS_MAX shows that the pass limit alone does not start a second pass. Counts of 9, 17 and 31 run two, three and four passes. Their written values only match when the stored colour is read back, merged and written in the right cycles. A black base colour shows that modulate keeps zero. While each pixel is in flight, a different pixel is held on the input, and the write trace shows that it never gets in.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

    typedef logic [23:0] rgb_t;

    localparam rgb_t RGB_WHITE = 24'hFFFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TEX,
        ST_FBRD,
        ST_MERGE,
        ST_WRITE
    } lbt_state_t;

    // Per-channel modulate with rounding up: (x*y + 255) >> 8
    function automatic logic [7:0] mod8(input logic [7:0] x, input logic [7:0] y);
        logic [15:0] prod;
        prod = {8'h00, x} * {8'h00, y};
        prod = prod + 16'd255;
        return prod[15:8];
    endfunction

    function automatic rgb_t mod_rgb(input rgb_t x, input rgb_t y);
        rgb_t r;
        for (int c = 0; c < 3; c++) begin
            r[c*8 +: 8] = mod8(x[c*8 +: 8], y[c*8 +: 8]);
        end
        return r;
    endfunction

endpackage

// File: rtl/lbt_texel_stub.sv
module lbt_texel_stub
    import lbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  tex_idx,
    output rgb_t              texel
);

    logic [7:0] addr8;
    logic [7:0] idx8;
    logic [7:0] idx_mul;

    assign addr8   = 8'(addr);
    assign idx8    = 8'(tex_idx);
    assign idx_mul = idx8 * 8'd17;

    // The lookup result is consumed in the loop cycle that requests it
    for (genvar c = 0; c < 3; c++) begin : g_chan
        assign texel[c*8 +: 8] = (addr8 + idx_mul + 8'(85 * c)) | 8'h80;
    end

endmodule

// File: rtl/lbt_tex_stage.sv
module lbt_tex_stage
    import lbt_pkg::*;
#(
    parameter int NUM_TU = 2,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 5,
    localparam int LANE_W = $clog2(NUM_TU + 1)
) (
    input  rgb_t              col_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  first_idx,
    input  logic [LANE_W-1:0] lanes,
    output rgb_t              col_out
);

    logic [NUM_TU:0][23:0] chain;

    assign chain[0] = col_in;

    for (genvar i = 0; i < NUM_TU; i++) begin : g_lane
        logic [CNT_W-1:0] idx;
        rgb_t             tex;

        assign idx = first_idx + CNT_W'(i);

        lbt_texel_stub #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W)
        ) u_stub (
            .addr    (addr),
            .tex_idx (idx),
            .texel   (tex)
        );

        // Idle lanes pass the colour through untouched
        assign chain[i+1] = (lanes > LANE_W'(i)) ? mod_rgb(chain[i], tex) : chain[i];
    end

    assign col_out = chain[NUM_TU];

endmodule

// File: rtl/lbt_ctrl.sv
module lbt_ctrl
    import lbt_pkg::*;
#(
    parameter int NUM_TU   = 2,
    parameter int PASS_MAX = 8,
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 5,
    localparam int LANE_W  = $clog2(NUM_TU + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  rgb_t              in_base,
    input  logic [CNT_W-1:0]  in_tex_cnt,
    input  rgb_t              stage_col,
    input  rgb_t              fb_rd_data,
    output logic              in_ready,
    output logic              busy,
    output logic              fb_rd_en,
    output logic              fb_wr_en,
    output logic [ADDR_W-1:0] fb_addr,
    output rgb_t              fb_wr_data,
    output logic              done,
    output rgb_t              out_colour,
    output logic [CNT_W-1:0]  pass_idx,
    output rgb_t              stage_src,
    output logic [CNT_W-1:0]  stage_first,
    output logic [LANE_W-1:0] stage_lanes
);

    localparam logic [CNT_W-1:0] LIM  = CNT_W'(PASS_MAX);
    localparam logic [CNT_W-1:0] TU_C = CNT_W'(NUM_TU);

    function automatic logic [CNT_W-1:0] clip_pass(input logic [CNT_W-1:0] n);
        return (n > LIM) ? LIM : n;
    endfunction

    lbt_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    rgb_t              col_q;
    logic [CNT_W-1:0]  total_q;
    logic [CNT_W-1:0]  applied_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  pass_q;

    logic [CNT_W-1:0]  step;
    logic              last;

    assign step = (left_q > TU_C) ? TU_C : left_q;
    assign last = (applied_q == total_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = (in_tex_cnt == '0) ? ST_WRITE : ST_TEX;
                end
            end
            ST_TEX: begin
                if (left_q == step) begin
                    state_d = (pass_q == '0) ? ST_WRITE : ST_FBRD;
                end
            end
            ST_FBRD:  state_d = ST_MERGE;
            ST_MERGE: state_d = ST_WRITE;
            ST_WRITE: state_d = last ? ST_IDLE : ST_TEX;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Pixel context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            col_q     <= '0;
            total_q   <= '0;
            applied_q <= '0;
            left_q    <= '0;
            pass_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        addr_q    <= in_addr;
                        col_q     <= in_base;
                        total_q   <= in_tex_cnt;
                        applied_q <= '0;
                        left_q    <= clip_pass(in_tex_cnt);
                        pass_q    <= '0;
                    end
                end
                ST_TEX: begin
                    col_q     <= stage_col;
                    applied_q <= applied_q + step;
                    left_q    <= left_q - step;
                end
                ST_FBRD: begin
                end
                ST_MERGE: begin
                    col_q <= mod_rgb(fb_rd_data, col_q);
                end
                ST_WRITE: begin
                    if (!last) begin
                        pass_q <= pass_q + 1'b1;
                        col_q  <= RGB_WHITE;
                        left_q <= clip_pass(total_q - applied_q);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready    = 1'b0;
        busy        = 1'b1;
        fb_rd_en    = 1'b0;
        fb_wr_en    = 1'b0;
        done        = 1'b0;
        stage_lanes = '0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                busy     = 1'b0;
            end
            ST_TEX:   stage_lanes = LANE_W'(step);
            ST_FBRD:  fb_rd_en = 1'b1;
            ST_MERGE: begin
            end
            ST_WRITE: begin
                fb_wr_en = 1'b1;
                done     = last;
            end
            default: begin
            end
        endcase
        fb_addr     = addr_q;
        fb_wr_data  = col_q;
        out_colour  = col_q;
        pass_idx    = pass_q;
        stage_src   = col_q;
        stage_first = applied_q;
    end

endmodule

// File: rtl/lbt_pipe.sv
module lbt_pipe
    import lbt_pkg::*;
#(
    parameter int NUM_TU   = 2,
    parameter int PASS_MAX = 8,
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [23:0]       in_base,
    input  logic [CNT_W-1:0]  in_tex_cnt,
    output logic              busy,
    output logic              fb_rd_en,
    output logic              fb_wr_en,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [23:0]       fb_wr_data,
    input  logic [23:0]       fb_rd_data,
    output logic              done,
    output logic [23:0]       out_colour,
    output logic [CNT_W-1:0]  pass_idx
);

    localparam int LANE_W = $clog2(NUM_TU + 1);

    rgb_t              stage_src;
    rgb_t              stage_col;
    logic [CNT_W-1:0]  stage_first;
    logic [LANE_W-1:0] stage_lanes;

    lbt_ctrl #(
        .NUM_TU   (NUM_TU),
        .PASS_MAX (PASS_MAX),
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_addr     (in_addr),
        .in_base     (in_base),
        .in_tex_cnt  (in_tex_cnt),
        .stage_col   (stage_col),
        .fb_rd_data  (fb_rd_data),
        .in_ready    (in_ready),
        .busy        (busy),
        .fb_rd_en    (fb_rd_en),
        .fb_wr_en    (fb_wr_en),
        .fb_addr     (fb_addr),
        .fb_wr_data  (fb_wr_data),
        .done        (done),
        .out_colour  (out_colour),
        .pass_idx    (pass_idx),
        .stage_src   (stage_src),
        .stage_first (stage_first),
        .stage_lanes (stage_lanes)
    );

    lbt_tex_stage #(
        .NUM_TU (NUM_TU),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_stage (
        .col_in    (stage_src),
        .addr      (fb_addr),
        .first_idx (stage_first),
        .lanes     (stage_lanes),
        .col_out   (stage_col)
    );

endmodule

// File: rtl/lbt_pipe_chk.sv
module lbt_pipe_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              busy,
    input logic              fb_rd_en,
    input logic              fb_wr_en,
    input logic [ADDR_W-1:0] fb_addr,
    input logic              done,
    input logic [CNT_W-1:0]  pass_idx
);

    p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready);

    p_rd_merge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd_en |=> (!fb_wr_en && !fb_rd_en));

    p_rd_then_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd_en |=> ##1 fb_wr_en);

    p_rd_later_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd_en |-> (pass_idx != '0));

    p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fb_rd_en && fb_wr_en));

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fb_addr));

    p_pass_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (pass_idx != $past(pass_idx)))
            |-> (pass_idx == CNT_W'($past(pass_idx) + 1'b1)));

endmodule

bind lbt_pipe lbt_pipe_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy),
    .fb_rd_en (fb_rd_en),
    .fb_wr_en (fb_wr_en),
    .fb_addr  (fb_addr),
    .done     (done),
    .pass_idx (pass_idx)
);

// File: tb/lbt_pipe_tb.sv
`timescale 1ns/1ps
module lbt_pipe_tb;

    localparam int NTU  = 2;
    localparam int LIMP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_addr = '0;
    logic [23:0] in_base = '0;
    logic [4:0]  in_tex_cnt = '0;
    logic        busy;
    logic        fb_rd_en;
    logic        fb_wr_en;
    logic [7:0]  fb_addr;
    logic [23:0] fb_wr_data;
    logic [23:0] fb_rd_data = '0;
    logic        done;
    logic [23:0] out_colour;
    logic [4:0]  pass_idx;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [23:0] mem [256];

    logic        e_wr   [64];
    logic        e_rd   [64];
    logic        e_done [64];
    logic [23:0] e_data [64];
    int          e_pass [64];

    always #4 clk = ~clk;

    lbt_pipe u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_addr    (in_addr),
        .in_base    (in_base),
        .in_tex_cnt (in_tex_cnt),
        .busy       (busy),
        .fb_rd_en   (fb_rd_en),
        .fb_wr_en   (fb_wr_en),
        .fb_addr    (fb_addr),
        .fb_wr_data (fb_wr_data),
        .fb_rd_data (fb_rd_data),
        .done       (done),
        .out_colour (out_colour),
        .pass_idx   (pass_idx)
    );

    // Synchronous frame buffer, one cycle read latency
    always @(posedge clk) begin
        if (fb_wr_en) mem[fb_addr] <= fb_wr_data;
        if (fb_rd_en) fb_rd_data <= mem[fb_addr];
    end

    function automatic logic [23:0] texrgb(input int a, input int k);
        logic [23:0] r;
        for (int c = 0; c < 3; c++) begin
            r[c*8 +: 8] = 8'(((a & 255) + 17 * k + 85 * c) % 256) | 8'h80;
        end
        return r;
    endfunction

    function automatic logic [23:0] mrgb(input logic [23:0] x, input logic [23:0] y);
        logic [23:0] r;
        for (int c = 0; c < 3; c++) begin
            r[c*8 +: 8] = 8'((int'(x[c*8 +: 8]) * int'(y[c*8 +: 8]) + 255) >> 8);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(in_ready == 1'b1, req, "in_ready idle", in_ready, 1);
        chk(busy == 1'b0, req, "busy idle", busy, 0);
        chk(fb_wr_en == 1'b0 && fb_rd_en == 1'b0, req, "fb strobes idle",
            {fb_wr_en, fb_rd_en}, 0);
        chk(done == 1'b0, req, "done idle", done, 0);
    endtask

    task automatic run_pixel(input int a, input logic [23:0] base, input int t,
                             input string tag);
        int k;
        int appl;
        int p;
        int n;
        int cyc;
        logic [23:0] col;
        logic [23:0] fbv;
        for (int i = 0; i < 64; i++) begin
            e_wr[i] = 1'b0; e_rd[i] = 1'b0; e_done[i] = 1'b0;
            e_data[i] = '0; e_pass[i] = 0;
        end
        k = 0; appl = 0; p = 0; fbv = '0;
        if (t == 0) begin
            k = 1; e_wr[1] = 1'b1; e_data[1] = base; e_done[1] = 1'b1;
        end else begin
            while (appl < t) begin
                n = (t - appl > LIMP) ? LIMP : t - appl;
                col = (p == 0) ? base : 24'hFFFFFF;
                for (int j = 0; j < n; j++) col = mrgb(col, texrgb(a, appl + j));
                cyc = (n + NTU - 1) / NTU;
                for (int j = 0; j < cyc; j++) begin k++; e_pass[k] = p; end
                if (p > 0) begin
                    k++; e_rd[k] = 1'b1; e_pass[k] = p;
                    k++; e_pass[k] = p;
                    col = mrgb(fbv, col);
                end
                k++; e_wr[k] = 1'b1; e_data[k] = col; e_pass[k] = p;
                fbv = col;
                appl += n;
                if (appl == t) e_done[k] = 1'b1;
                p++;
            end
        end

        @(negedge clk);
        chk_idle("R5");
        in_valid   = 1'b1;
        in_addr    = 8'(a);
        in_base    = base;
        in_tex_cnt = 5'(t);
        for (int c = 1; c <= k; c++) begin
            @(negedge clk);
            chk(busy == 1'b1, "R4", "busy while in flight", busy, 1);
            chk(in_ready == 1'b0, "R5", "in_ready while busy", in_ready, 0);
            chk(fb_wr_en == e_wr[c], "R7", "fb_wr_en", fb_wr_en, e_wr[c]);
            chk(fb_rd_en == e_rd[c], "R10", "fb_rd_en", fb_rd_en, e_rd[c]);
            chk(done == e_done[c], "R9", "done", done, e_done[c]);
            chk(int'(pass_idx) == e_pass[c], "R9", "pass_idx", pass_idx, e_pass[c]);
            chk(fb_addr == 8'(a), "R7", "fb_addr", fb_addr, a);
            if (e_wr[c]) chk(fb_wr_data == e_data[c], tag, "written colour",
                             fb_wr_data, e_data[c]);
            if (e_done[c]) chk(out_colour == e_data[c], "R9", "out_colour",
                               out_colour, e_data[c]);
            // Offer a different pixel while busy; it must be ignored
            if (c < k) begin
                in_valid   = 1'b1;
                in_addr    = 8'(a) ^ 8'hFF;
                in_base    = ~base;
                in_tex_cnt = 5'd31;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 24'h5A5A5A ^ 24'(i * 7919);
        repeat (3) @(negedge clk);
        chk_idle("R1");
        chk(pass_idx == '0, "R1", "pass_idx in reset", pass_idx, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");
        chk(pass_idx == '0, "R1", "pass_idx after reset", pass_idx, 0);

        run_pixel(8'h10, 24'h806040, 0,  "R6");
        run_pixel(8'h21, 24'hFFFFFF, 1,  "R2");
        run_pixel(8'h22, 24'hC08040, 2,  "R3");
        run_pixel(8'h23, 24'h9F3F7F, 3,  "R4");
        run_pixel(8'h30, 24'hF0E0D0, 8,  "R3");
        run_pixel(8'h40, 24'h000000, 5,  "R3");
        run_pixel(8'h31, 24'hA0B0C0, 9,  "R8");
        run_pixel(8'h32, 24'hFF8001, 17, "R8");
        run_pixel(8'hFE, 24'h7F7F7F, 31, "R7");
        run_pixel(8'h33, 24'h123456, 0,  "R6");

        @(negedge clk);
        chk_idle("R5");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R4 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule